// File: doc/BRIEF.md
# Transceiver Wake Qualifier

This block watches for wake requests while a bus transceiver sleeps in its power-down state. It also turns a raw chip-select input into a clean, glitch-free level. Three sources can raise a wake request. The first is the sampled bus line. The second is a local wake pin. The third is a rising filtered chip-select. All three are honoured only while the power-down indication is high. The block reports a wake as a single-clock pulse, which the power controller uses to leave power-down.

A bus wake is not a bare edge. The line must first move to the active level of the configured polarity and then stay there for a minimum number of timebase ticks. In falling mode the active level is low and the hold defaults to 20 ticks (20 µs at a 1 µs tick). In rising mode the active level is high and the hold defaults to 70 ticks. If the line returns to idle early, the qualification is dropped.

The chip-select filter is a digital persistence filter clocked by the same tick, with a default of 10 ticks. Short pulses therefore neither wake the device nor change the filtered level that sends it to power-down. Both the filtered level and its counter reset to 0, which models the input's default pull-down.

Top module: `wake_qualifier`

## Requirements
- R1: While rst_n is low, and in the first cycle after it, cs_filt reads 0 and wake_pulse reads 0, whatever the inputs are.
- R2: cs_filt takes the level of cs_raw only after cs_raw has differed from cs_filt on CS_FILTER_TICKS consecutive ticks. If cs_raw matches cs_filt again first, the count restarts, so a shorter pulse leaves cs_filt unchanged.
- R3: Filter and hold counters advance only in cycles where tick is 1. A cycle without a tick neither advances nor clears a count in progress.
- R4: With BUS_WAKE_RISING=0, bus_in falls from 1 to 0 while pd_in=1. Counting starts in the cycle after the edge. If the line then stays 0 for BUS_FALL_HOLD_TICKS ticks, wake_pulse goes to 1 in the cycle after the last of those ticks is sampled. A rising edge never qualifies in this mode.
- R5: With BUS_WAKE_RISING=1, the same rule applies to a 0-to-1 edge on bus_in followed by BUS_RISE_HOLD_TICKS ticks at 1. A falling edge never qualifies in this mode.
- R6: If bus_in returns to its idle level before the hold completes, no wake is issued. The next qualifying edge starts a fresh count from zero.
- R7: A bus level that is already active when pd_in rises, with no edge seen under power-down, issues no wake. One qualified edge issues exactly one wake, however long the level is then held.
- R8: A 1-to-0 step on local_wake_in while pd_in=1 raises wake_pulse in the next cycle. Holding the pin low produces no further wake.
- R9: A 0-to-1 change of cs_filt while pd_in=1 raises wake_pulse in the same cycle that cs_filt changes. A 1-to-0 change of cs_filt raises no wake.
- R10: While pd_in=0, no source produces a wake. A bus qualification in progress is dropped when pd_in falls.
- R11: wake_pulse is never 1 in two consecutive cycles. A request in the cycle right after a pulse is absorbed into that pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| tick | input | 1 | Timebase strobe; counts hold and filter time |
| bus_in | input | 1 | Sampled bus line level (1 = recessive) |
| local_wake_in | input | 1 | Local wake pin; a falling step requests a wake |
| cs_raw | input | 1 | Unfiltered chip-select level |
| pd_in | input | 1 | High while the transceiver is in power-down |
| cs_filt | output | 1 | Glitch-filtered chip-select level |
| wake_pulse | output | 1 | One-cycle wake event |

## Verification
Suppose the bus hold counter is off by one, or fails to restart. Then wake_pulse moves by a cycle, or appears after an early revert, and the bench sees this the first cycle after the expected hold ends. Suppose instead the chip-select counter keeps stale counts across a matching sample. Then a short pulse will be enough to flip cs_filt, and this shows within a few ticks of the glitch. If the armed flag or the merge register is stuck, the result is a missing, doubled or repeated wake_pulse. That shows up in the cycles right after a qualification or a local-pin step.

// File: rtl/wq_pkg.sv
package wq_pkg;

  // Hold time the bus must stay at its active level, chosen by polarity.
  function automatic int unsigned bus_hold_ticks(bit rising,
                                                 int unsigned fall_ticks,
                                                 int unsigned rise_ticks);
    return rising ? rise_ticks : fall_ticks;
  endfunction

  // Counter width large enough to hold values up to lim.
  function automatic int unsigned ctr_bits(int unsigned lim);
    return (lim < 2) ? 1 : $clog2(lim + 1);
  endfunction

  // Level that a qualifying bus edge lands on.
  function automatic logic active_level(bit rising);
    return rising ? 1'b1 : 1'b0;
  endfunction

endpackage

// File: rtl/wq_persist_filter.sv
module wq_persist_filter
  import wq_pkg::*;
#(
  parameter int unsigned TICKS     = 10,
  parameter logic        RST_LEVEL = 1'b0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  input  logic din,
  output logic q,
  output logic rise
);
  localparam int unsigned CW = ctr_bits(TICKS);

  logic [CW-1:0] cnt;
  logic          differ;
  logic          step;
  logic          done;

  assign differ = (din != q);
  assign step   = differ && tick;
  assign done   = step && (cnt == CW'(TICKS - 1));
  assign rise   = done && din;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q   <= RST_LEVEL;
      cnt <= '0;
    end else if (!differ) begin
      cnt <= '0;
    end else if (done) begin
      q   <= din;
      cnt <= '0;
    end else if (step) begin
      cnt <= cnt + 1'b1;
    end
  end

endmodule

// File: rtl/wq_bus_qual.sv
module wq_bus_qual
  import wq_pkg::*;
#(
  parameter bit          RISING = 1'b0,
  parameter int unsigned HOLD   = 20
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  input  logic enable,
  input  logic bus,
  output logic hit
);
  localparam logic        ACT = active_level(RISING);
  localparam int unsigned CW  = ctr_bits(HOLD);

  logic          prev;
  logic          armed;
  logic [CW-1:0] cnt;
  logic          edge_seen;
  logic          arm_now;
  logic          held;

  generate
    if (RISING) begin : g_rise
      assign edge_seen = bus & ~prev;
    end else begin : g_fall
      assign edge_seen = ~bus & prev;
    end
  endgenerate

  assign arm_now = enable && edge_seen;
  assign held    = armed && enable && (bus == ACT);
  assign hit     = held && tick && (cnt == CW'(HOLD - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev  <= ~ACT;
      armed <= 1'b0;
      cnt   <= '0;
    end else begin
      prev <= bus;
      if (arm_now) begin
        armed <= 1'b1;
        cnt   <= '0;
      end else if (!held || hit) begin
        armed <= 1'b0;
        cnt   <= '0;
      end else if (tick) begin
        cnt <= cnt + 1'b1;
      end
    end
  end

endmodule

// File: rtl/wq_local_edge.sv
module wq_local_edge (
  input  logic clk,
  input  logic rst_n,
  input  logic enable,
  input  logic pin,
  output logic hit
);
  logic prev;

  assign hit = enable && prev && !pin;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev <= 1'b1;
    else        prev <= pin;
  end

endmodule

// File: rtl/wake_qualifier.sv
module wake_qualifier
  import wq_pkg::*;
#(
  parameter bit          BUS_WAKE_RISING     = 1'b0,
  parameter int unsigned BUS_FALL_HOLD_TICKS = 20,
  parameter int unsigned BUS_RISE_HOLD_TICKS = 70,
  parameter int unsigned CS_FILTER_TICKS     = 10
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  input  logic bus_in,
  input  logic local_wake_in,
  input  logic cs_raw,
  input  logic pd_in,
  output logic cs_filt,
  output logic wake_pulse
);
  localparam int unsigned HOLD =
    bus_hold_ticks(BUS_WAKE_RISING, BUS_FALL_HOLD_TICKS, BUS_RISE_HOLD_TICKS);

  logic bus_hit;
  logic lw_hit;
  logic cs_rise;
  logic cs_rise_hit;
  logic any_req;
  logic wake_q;

  wq_persist_filter #(.TICKS(CS_FILTER_TICKS), .RST_LEVEL(1'b0)) u_cs_filt (
    .clk  (clk),
    .rst_n(rst_n),
    .tick (tick),
    .din  (cs_raw),
    .q    (cs_filt),
    .rise (cs_rise)
  );

  wq_bus_qual #(.RISING(BUS_WAKE_RISING), .HOLD(HOLD)) u_bus (
    .clk   (clk),
    .rst_n (rst_n),
    .tick  (tick),
    .enable(pd_in),
    .bus   (bus_in),
    .hit   (bus_hit)
  );

  wq_local_edge u_lw (
    .clk   (clk),
    .rst_n (rst_n),
    .enable(pd_in),
    .pin   (local_wake_in),
    .hit   (lw_hit)
  );

  assign cs_rise_hit = cs_rise && pd_in;
  assign any_req     = bus_hit || lw_hit || cs_rise_hit;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) wake_q <= 1'b0;
    else        wake_q <= any_req && !wake_q;
  end

  assign wake_pulse = wake_q;

endmodule

// File: rtl/wq_chk.sv
module wq_chk #(
  parameter bit ACT_LEVEL = 1'b0
) (
  input logic clk,
  input logic rst_n,
  input logic tick,
  input logic pd_in,
  input logic bus_in,
  input logic cs_raw,
  input logic cs_filt,
  input logic wake_pulse,
  input logic bus_hit,
  input logic lw_hit
);

  // R11
  single_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wake_pulse |=> !wake_pulse);

  // R10
  pd_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !pd_in |=> !wake_pulse);

  // R2
  cs_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(cs_filt) |-> ($past(cs_raw) == cs_filt) && $past(tick));

  // R4
  bus_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bus_hit |-> (bus_in == ACT_LEVEL) && tick && pd_in);

  // R8
  lw_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (lw_hit && !wake_pulse) |=> wake_pulse);

endmodule

bind wake_qualifier wq_chk #(.ACT_LEVEL(BUS_WAKE_RISING)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .tick      (tick),
  .pd_in     (pd_in),
  .bus_in    (bus_in),
  .cs_raw    (cs_raw),
  .cs_filt   (cs_filt),
  .wake_pulse(wake_pulse),
  .bus_hit   (bus_hit),
  .lw_hit    (lw_hit)
);

// File: tb/tb_wake_qualifier.sv
`timescale 1ns/1ps
module tb_wake_qualifier;
  localparam int CSF = 3;
  localparam int FH  = 4;
  localparam int RH  = 6;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic tick = 1'b1;
  logic pd = 1'b0;
  logic lw = 1'b1;
  logic cs = 1'b0;
  logic bus = 1'b1;
  logic bus_r = 1'b0;
  logic cs_f, wk, cs_f_r, wk_r;
  int checks = 0;
  int errors = 0;

  always #2 clk = ~clk;

  wake_qualifier #(.BUS_WAKE_RISING(1'b0), .BUS_FALL_HOLD_TICKS(FH),
                   .BUS_RISE_HOLD_TICKS(RH), .CS_FILTER_TICKS(CSF)) dut (
    .clk(clk), .rst_n(rst_n), .tick(tick), .bus_in(bus), .local_wake_in(lw),
    .cs_raw(cs), .pd_in(pd), .cs_filt(cs_f), .wake_pulse(wk));

  wake_qualifier #(.BUS_WAKE_RISING(1'b1), .BUS_FALL_HOLD_TICKS(FH),
                   .BUS_RISE_HOLD_TICKS(RH), .CS_FILTER_TICKS(CSF)) dut_r (
    .clk(clk), .rst_n(rst_n), .tick(tick), .bus_in(bus_r), .local_wake_in(lw),
    .cs_raw(cs), .pd_in(pd), .cs_filt(cs_f_r), .wake_pulse(wk_r));

  task automatic chk(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0b expected %0b", req, act, exp);
    end
  endtask

  // Row fields: {pd, local_wake, cs_raw, bus, tick, expected wake, expected cs_filt}
  // Rows 1-3 local wake (R8), 4-14 filter and tick gating (R2, R3, R9),
  // 15-18 no wake while pd low (R10).
  localparam logic [6:0] VEC [20] = '{
    7'b1101100, 7'b1001110, 7'b1001100, 7'b1101100, 7'b1111100,
    7'b1111100, 7'b1101100, 7'b1111100, 7'b1111000, 7'b1111100,
    7'b1111111, 7'b1111101, 7'b1101101, 7'b1101101, 7'b1101100,
    7'b0111100, 7'b0111100, 7'b0111101, 7'b0011101, 7'b1111101
  };

  initial begin
    // R1: reset state with chip-select driven high
    cs = 1'b1;
    repeat (3) @(negedge clk);
    chk("R1 cs_filt in reset", cs_f, 1'b0);
    chk("R1 wake in reset", wk, 1'b0);
    cs = 1'b0;
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 cs_filt after reset", cs_f, 1'b0);
    chk("R1 wake after reset", wk, 1'b0);

    for (int i = 0; i < 20; i++) begin
      pd = VEC[i][6]; lw = VEC[i][5]; cs = VEC[i][4];
      bus = VEC[i][3]; tick = VEC[i][2];
      @(negedge clk);
      chk($sformatf("R2/R3/R8/R9/R10 row %0d wake", i), wk, VEC[i][1]);
      chk($sformatf("R2/R3/R9/R10 row %0d cs_filt", i), cs_f, VEC[i][0]);
    end

    // R4: falling edge, full hold, then one pulse only (R7)
    bus = 1'b0;
    for (int k = 1; k <= FH + 1; k++) begin
      @(negedge clk);
      chk("R4 falling hold", wk, logic'(k == FH + 1));
    end
    for (int k = 0; k < 6; k++) begin
      @(negedge clk);
      chk("R7 held level no repeat", wk, 1'b0);
    end
    bus = 1'b1;
    @(negedge clk);

    // R6: early revert, then a fresh full qualification
    bus = 1'b0;
    repeat (FH - 1) @(negedge clk);
    bus = 1'b1;
    for (int k = 0; k < FH + 2; k++) begin
      @(negedge clk);
      chk("R6 revert no wake / R4 rising ignored", wk, 1'b0);
    end
    bus = 1'b0;
    for (int k = 1; k <= FH + 1; k++) begin
      @(negedge clk);
      chk("R6 restarted count", wk, logic'(k == FH + 1));
    end
    bus = 1'b1;
    @(negedge clk);

    // R3: ticks withheld after the edge
    bus = 1'b0;
    tick = 1'b0;
    for (int k = 0; k < 5; k++) begin
      @(negedge clk);
      chk("R3 no tick no count", wk, 1'b0);
    end
    tick = 1'b1;
    for (int k = 1; k <= FH + 1; k++) begin
      @(negedge clk);
      chk("R3 tick gated hold", wk, logic'(k == FH));
    end
    bus = 1'b1;
    @(negedge clk);

    // R7: level already low before power-down
    pd = 1'b0;
    bus = 1'b0;
    repeat (3) @(negedge clk);
    pd = 1'b1;
    for (int k = 0; k < FH + 4; k++) begin
      @(negedge clk);
      chk("R7 no edge no wake", wk, 1'b0);
    end
    bus = 1'b1;
    @(negedge clk);

    // R10: pd drops during qualification
    bus = 1'b0;
    repeat (2) @(negedge clk);
    pd = 1'b0;
    for (int k = 0; k < FH + 2; k++) begin
      @(negedge clk);
      chk("R10 pd low drops hold", wk, 1'b0);
    end
    pd = 1'b1;
    bus = 1'b1;
    @(negedge clk);

    // R5: rising polarity instance
    bus_r = 1'b1;
    for (int k = 1; k <= RH + 1; k++) begin
      @(negedge clk);
      chk("R5 rising hold", wk_r, logic'(k == RH + 1));
    end
    bus_r = 1'b0;
    for (int k = 0; k < RH + 3; k++) begin
      @(negedge clk);
      chk("R5 falling ignored", wk_r, 1'b0);
    end

    // R11: cs rise pulse followed by a local-pin step next cycle
    cs = 1'b0;
    for (int k = 0; k < CSF; k++) begin
      @(negedge clk);
      chk("R9 cs fall no wake", wk, 1'b0);
    end
    chk("R2 cs_filt low", cs_f, 1'b0);
    cs = 1'b1;
    repeat (2) begin
      @(negedge clk);
      chk("R11 before pulse", wk, 1'b0);
    end
    @(negedge clk);
    chk("R9 cs rise wake", wk, 1'b1);
    lw = 1'b0;
    @(negedge clk);
    chk("R11 absorbed request", wk, 1'b0);
    @(negedge clk);
    chk("R11 stays low", wk, 1'b0);
    lw = 1'b1;
    @(negedge clk);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (50000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule